// File: doc/BRIEF.md
# Coherent Line Permission Controller

This block sits on the client side of a coherent interconnect that carries its messages on five separate channels. It keeps a small register array of cache lines. Each line has a permission level (Trunk: exclusive and writable, Branch: shared read-only, or None) and a dirty flag. A core-side port reads and writes lines. When the local permission is too weak, the block stalls the core. It then sends an acquire, installs the granted data and permission, and closes the exchange with an acknowledge.

The manager can send probes that ask the block to lower a line's permission. The block answers each probe with a report on the release/probe-response channel, and that report carries the line data when the line was dirty. A probe that arrives while an acquire is waiting for its grant is answered first, using the line's current state. The core side can also ask for a voluntary release. A shared line is dropped silently. An exclusive line is written back and the block waits for the manager's release acknowledge.

Only one exchange is in flight at a time. Each channel uses a valid/ready handshake and holds its payload until the transfer happens.

Top module: `coh_perm_ctl`

## Requirements
- R1: After reset every line holds permission None and every channel valid the block drives (acquire, response, acknowledge, core read response) is low.
- R2: A core read of a line in Branch or Trunk is accepted at once with no channel traffic, and rspValid/rspData present the line data in the cycle after acceptance.
- R3: A core access that lacks permission is stalled (reqReady low) and an acquire is issued for that line with grow code 0 (to-Trunk) for a write or 1 (to-Branch) for a read.
- R4: While waiting, a grant on the grant channel (dRelAck=0) installs dData with the permission in dCap (0 Trunk, 1 Branch) and clean state, then the acknowledge channel raises eValid for that line, and the block returns to idle when eReady is high.
- R5: A line reaches Trunk only from a grant carrying code 0, and a write to a Branch line is never accepted without one.
- R6: A core write to a Trunk line is accepted at once, updates the data and marks the line dirty.
- R7: A probe (cap code 0 keep, 1 to-Branch, 2 to-None) is answered on the response channel with cVoluntary=0 and cReport giving the resulting permission code (0/1/2). cHasData=1 and cData hold the line data only when a dirty Trunk line loses Trunk. The line takes the reported permission and its dirty flag clears.
- R8: A probe arriving while an acquire waits for its grant is taken before the grant (dReady held low while bValid is high), it is answered from the line's current state, and the acquire then completes.
- R9: A voluntary release of a Branch line drops it to None with no message. A release of a Trunk line sends cVoluntary=1 and cReport=2 with data flagged when dirty, drops the line, and returns to idle on a grant-channel beat with dRelAck=1.
- R10: Every outgoing channel keeps valid and payload stable while valid is high and ready is low.
- R11: At most one of the acquire, response and acknowledge channels is valid at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core access request |
| reqReady | output | 1 | Core access accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLine | input | LINE_W | Line index of core access |
| reqData | input | DATA_W | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | DATA_W | Read data |
| relValid | input | 1 | Voluntary release request |
| relReady | output | 1 | Release request accepted |
| relLine | input | LINE_W | Line to release |
| aValid | output | 1 | Acquire valid |
| aReady | input | 1 | Acquire ready |
| aLine | output | LINE_W | Acquire line |
| aGrow | output | 2 | Requested permission code |
| bValid | input | 1 | Probe valid |
| bReady | output | 1 | Probe ready |
| bLine | input | LINE_W | Probed line |
| bCap | input | 2 | Probe permission cap code |
| cValid | output | 1 | Response/release valid |
| cReady | input | 1 | Response/release ready |
| cLine | output | LINE_W | Line reported |
| cReport | output | 2 | Resulting permission code |
| cVoluntary | output | 1 | 1 = voluntary release, 0 = probe answer |
| cHasData | output | 1 | cData carries dirty line data |
| cData | output | DATA_W | Line data |
| dValid | input | 1 | Grant / release-ack valid |
| dReady | output | 1 | Grant channel ready |
| dCap | input | 2 | Granted permission code |
| dRelAck | input | 1 | 1 = release acknowledge, 0 = grant |
| dData | input | DATA_W | Granted line data |
| eValid | output | 1 | Grant acknowledge valid |
| eReady | input | 1 | Grant acknowledge ready |
| eLine | output | LINE_W | Acknowledged line |

## Verification
The assertions take a well-behaved manager as given. It sends a grant only while an acquire is pending and a release acknowledge only after a release. Its grant is for the line just requested and carries a permission code of 0 or 1, and its probe cap codes are 0 to 2. Under these conditions, Trunk is only reachable through a grant and an acknowledge always follows one. The directed scenarios play that manager role by hand. They raise grant beats only in the waiting states and return release acknowledges only after a release has gone out. To exercise the hold and priority rules, they deliberately hold ready low and present a probe and a grant in the same cycle.

// File: rtl/coh_perm_pkg.sv
package coh_perm_pkg;
  typedef enum logic [1:0] {
    PERM_T = 2'd0,
    PERM_B = 2'd1,
    PERM_N = 2'd2
  } perm_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ACQ_SEND, S_ACQ_WAIT, S_ACK, S_PRB, S_REL_SEND, S_REL_WAIT
  } fsm_e;

  typedef struct packed {
    logic latchAcq;
    logic latchProbe;
    logic latchRel;
    logic applyProbe;
    logic dropRel;
    logic dropBranch;
    logic install;
    logic coreWrite;
    logic coreRead;
  } strobe_t;

  function automatic perm_e probeResult(perm_e cur, perm_e cap);
    if (cap == PERM_N) return PERM_N;
    if (cap == PERM_B && cur == PERM_T) return PERM_B;
    return cur;
  endfunction
endpackage

// File: rtl/coh_perm_dp.sv
module coh_perm_dp
  import coh_perm_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W = 32,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic                    reqWrite,
  input  logic [LINE_W-1:0]       reqLine,
  input  logic [DATA_W-1:0]       reqData,
  input  logic [LINE_W-1:0]       relLine,
  input  logic [LINE_W-1:0]       bLine,
  input  perm_e                   bCap,
  input  perm_e                   dCap,
  input  logic [DATA_W-1:0]       dData,
  output perm_e                   reqState,
  output perm_e                   relState,
  output logic                    rspValid,
  output logic [DATA_W-1:0]       rspData,
  output logic [LINE_W-1:0]       aLine,
  output perm_e                   aGrow,
  output logic [LINE_W-1:0]       cLine,
  output perm_e                   cReport,
  output logic                    cVoluntary,
  output logic                    cHasData,
  output logic [DATA_W-1:0]       cData,
  output logic [2*NUM_LINES-1:0]  lineStateFlat
);
  perm_e             perm  [NUM_LINES];
  logic              dirty [NUM_LINES];
  logic [DATA_W-1:0] store [NUM_LINES];

  assign reqState = perm[reqLine];
  assign relState = perm[relLine];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
    assign lineStateFlat[2*g +: 2] = perm[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        perm[i]  <= PERM_N;
        dirty[i] <= 1'b0;
        store[i] <= '0;
      end
      rspValid   <= 1'b0;
      rspData    <= '0;
      aLine      <= '0;
      aGrow      <= PERM_B;
      cLine      <= '0;
      cReport    <= PERM_N;
      cVoluntary <= 1'b0;
      cHasData   <= 1'b0;
      cData      <= '0;
    end else begin
      rspValid <= stb.coreRead;
      if (stb.coreRead) rspData <= store[reqLine];
      if (stb.coreWrite) begin
        store[reqLine] <= reqData;
        dirty[reqLine] <= 1'b1;
      end
      if (stb.latchAcq) begin
        aLine <= reqLine;
        aGrow <= reqWrite ? PERM_T : PERM_B;
      end
      if (stb.latchProbe) begin
        cLine      <= bLine;
        cVoluntary <= 1'b0;
        cReport    <= probeResult(perm[bLine], bCap);
        cHasData   <= (perm[bLine] == PERM_T) && dirty[bLine] && (bCap != PERM_T);
        cData      <= store[bLine];
      end
      if (stb.latchRel) begin
        cLine      <= relLine;
        cVoluntary <= 1'b1;
        cReport    <= PERM_N;
        cHasData   <= dirty[relLine];
        cData      <= store[relLine];
      end
      if (stb.applyProbe) begin
        perm[cLine] <= cReport;
        if (cHasData) dirty[cLine] <= 1'b0;
      end
      if (stb.dropRel) begin
        perm[cLine]  <= PERM_N;
        dirty[cLine] <= 1'b0;
      end
      if (stb.dropBranch) perm[relLine] <= PERM_N;
      if (stb.install) begin
        perm[aLine]  <= dCap;
        store[aLine] <= dData;
        dirty[aLine] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coh_perm_fsm.sv
module coh_perm_fsm
  import coh_perm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  perm_e   reqState,
  input  logic    relValid,
  input  perm_e   relState,
  input  logic    aReady,
  input  logic    bValid,
  input  logic    cReady,
  input  logic    dValid,
  input  logic    dRelAck,
  input  logic    eReady,
  output strobe_t stb,
  output logic    reqReady,
  output logic    relReady,
  output logic    aValid,
  output logic    bReady,
  output logic    cValid,
  output logic    dReady,
  output logic    eValid
);
  fsm_e state, nextState, retState, nextRet;
  logic hit;

  assign hit = reqWrite ? (reqState == PERM_T) : (reqState != PERM_N);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextRet   = retState;
    reqReady  = 1'b0;
    relReady  = 1'b0;
    aValid    = 1'b0;
    bReady    = 1'b0;
    cValid    = 1'b0;
    dReady    = 1'b0;
    eValid    = 1'b0;
    unique case (state)
      S_IDLE: begin
        bReady   = 1'b1;
        relReady = !bValid;
        reqReady = !bValid && !relValid && hit;
        if (bValid) begin
          stb.latchProbe = 1'b1;
          nextRet   = S_IDLE;
          nextState = S_PRB;
        end else if (relValid) begin
          if (relState == PERM_T) begin
            stb.latchRel = 1'b1;
            nextState = S_REL_SEND;
          end else if (relState == PERM_B) begin
            stb.dropBranch = 1'b1;
          end
        end else if (reqValid) begin
          if (hit) begin
            stb.coreWrite = reqWrite;
            stb.coreRead  = !reqWrite;
          end else begin
            stb.latchAcq = 1'b1;
            nextState = S_ACQ_SEND;
          end
        end
      end
      S_ACQ_SEND: begin
        aValid = 1'b1;
        if (aReady) nextState = S_ACQ_WAIT;
      end
      S_ACQ_WAIT: begin
        bReady = 1'b1;
        dReady = !bValid;
        if (bValid) begin
          stb.latchProbe = 1'b1;
          nextRet   = S_ACQ_WAIT;
          nextState = S_PRB;
        end else if (dValid && !dRelAck) begin
          stb.install = 1'b1;
          nextState = S_ACK;
        end
      end
      S_ACK: begin
        eValid = 1'b1;
        if (eReady) nextState = S_IDLE;
      end
      S_PRB: begin
        cValid = 1'b1;
        if (cReady) begin
          stb.applyProbe = 1'b1;
          nextState = retState;
        end
      end
      S_REL_SEND: begin
        cValid = 1'b1;
        if (cReady) begin
          stb.dropRel = 1'b1;
          nextState = S_REL_WAIT;
        end
      end
      S_REL_WAIT: begin
        dReady = 1'b1;
        if (dValid && dRelAck) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
    end else begin
      state    <= nextState;
      retState <= nextRet;
    end
  end
endmodule

// File: rtl/coh_perm_ctl.sv
module coh_perm_ctl
  import coh_perm_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W = 32,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              relValid,
  output logic              relReady,
  input  logic [LINE_W-1:0] relLine,
  output logic              aValid,
  input  logic              aReady,
  output logic [LINE_W-1:0] aLine,
  output logic [1:0]        aGrow,
  input  logic              bValid,
  output logic              bReady,
  input  logic [LINE_W-1:0] bLine,
  input  logic [1:0]        bCap,
  output logic              cValid,
  input  logic              cReady,
  output logic [LINE_W-1:0] cLine,
  output logic [1:0]        cReport,
  output logic              cVoluntary,
  output logic              cHasData,
  output logic [DATA_W-1:0] cData,
  input  logic              dValid,
  output logic              dReady,
  input  logic [1:0]        dCap,
  input  logic              dRelAck,
  input  logic [DATA_W-1:0] dData,
  output logic              eValid,
  input  logic              eReady,
  output logic [LINE_W-1:0] eLine
);
  strobe_t stb;
  perm_e reqState, relState, aGrowE, cReportE;
  logic [2*NUM_LINES-1:0] lineStateFlat;

  assign aGrow   = aGrowE;
  assign cReport = cReportE;
  assign eLine   = aLine;

  coh_perm_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqState(reqState), .relValid(relValid), .relState(relState),
    .aReady(aReady), .bValid(bValid), .cReady(cReady), .dValid(dValid),
    .dRelAck(dRelAck), .eReady(eReady), .stb(stb), .reqReady(reqReady),
    .relReady(relReady), .aValid(aValid), .bReady(bReady), .cValid(cValid),
    .dReady(dReady), .eValid(eValid)
  );

  coh_perm_dp #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqLine(reqLine),
    .reqData(reqData), .relLine(relLine), .bLine(bLine), .bCap(perm_e'(bCap)),
    .dCap(perm_e'(dCap)), .dData(dData), .reqState(reqState), .relState(relState),
    .rspValid(rspValid), .rspData(rspData), .aLine(aLine), .aGrow(aGrowE),
    .cLine(cLine), .cReport(cReportE), .cVoluntary(cVoluntary),
    .cHasData(cHasData), .cData(cData), .lineStateFlat(lineStateFlat)
  );
endmodule

// File: rtl/coh_perm_chk.sv
module coh_perm_chk #(
  parameter int NUM_LINES = 4,
  parameter int DATA_W = 32,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   aValid,
  input logic                   aReady,
  input logic [LINE_W-1:0]      aLine,
  input logic [1:0]             aGrow,
  input logic                   bValid,
  input logic                   bReady,
  input logic                   cValid,
  input logic                   cReady,
  input logic [LINE_W-1:0]      cLine,
  input logic [1:0]             cReport,
  input logic                   cHasData,
  input logic [DATA_W-1:0]      cData,
  input logic                   dValid,
  input logic                   dReady,
  input logic                   dRelAck,
  input logic [1:0]             dCap,
  input logic                   eValid,
  input logic                   eReady,
  input logic [LINE_W-1:0]      eLine,
  input logic [2*NUM_LINES-1:0] lineStateFlat
);
  assert_a_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && !aReady) |=> (aValid && $stable(aLine) && $stable(aGrow)));

  assert_c_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cValid && !cReady) |=> (cValid && $stable(cLine) && $stable(cReport)
                             && $stable(cHasData) && $stable(cData)));

  assert_e_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (eValid && !eReady) |=> (eValid && $stable(eLine)));

  assert_single_tx_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aValid, cValid, eValid}));

  assert_ack_after_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eValid) |-> $past(dValid && dReady && !dRelAck));

  assert_probe_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && bReady) |=> (cValid && !eValid));

  assert_probe_blocks_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> !(dValid && dReady && bReady));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_trunk
    assert_trunk_by_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
      (lineStateFlat[2*g +: 2] == 2'd0 && $past(lineStateFlat[2*g +: 2]) != 2'd0)
      |-> $past(dValid && dReady && !dRelAck && dCap == 2'd0 && aLine == LINE_W'(g)));
  end
endmodule

bind coh_perm_ctl coh_perm_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .aValid(aValid), .aReady(aReady), .aLine(aLine),
  .aGrow(aGrow), .bValid(bValid), .bReady(bReady), .cValid(cValid),
  .cReady(cReady), .cLine(cLine), .cReport(cReport), .cHasData(cHasData),
  .cData(cData), .dValid(dValid), .dReady(dReady), .dRelAck(dRelAck),
  .dCap(dCap), .eValid(eValid), .eReady(eReady), .eLine(eLine),
  .lineStateFlat(lineStateFlat)
);

// File: tb/coh_perm_ctl_bench.sv
module coh_perm_ctl_bench;
  localparam int NL = 4;
  localparam int DW = 32;
  localparam int LW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, relValid = 0;
  logic [LW-1:0] reqLine = '0, relLine = '0, bLine = '0;
  logic [DW-1:0] reqData = '0, dData = '0;
  logic aReady = 0, bValid = 0, cReady = 0, dValid = 0, dRelAck = 0, eReady = 0;
  logic [1:0] bCap = '0, dCap = '0;
  logic reqReady, rspValid, relReady, aValid, bReady, cValid, cVoluntary, cHasData;
  logic dReady, eValid;
  logic [DW-1:0] rspData, cData;
  logic [LW-1:0] aLine, cLine, eLine;
  logic [1:0] aGrow, cReport;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  coh_perm_ctl #(.NUM_LINES(NL), .DATA_W(DW)) u_coh_perm_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqLine(reqLine), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .relValid(relValid),
    .relReady(relReady), .relLine(relLine), .aValid(aValid), .aReady(aReady),
    .aLine(aLine), .aGrow(aGrow), .bValid(bValid), .bReady(bReady),
    .bLine(bLine), .bCap(bCap), .cValid(cValid), .cReady(cReady),
    .cLine(cLine), .cReport(cReport), .cVoluntary(cVoluntary),
    .cHasData(cHasData), .cData(cData), .dValid(dValid), .dReady(dReady),
    .dCap(dCap), .dRelAck(dRelAck), .dData(dData), .eValid(eValid),
    .eReady(eReady), .eLine(eLine)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // Acquire with immediate handshakes; leaves the block idle with reqValid low
  task automatic acquire(input logic [LW-1:0] ln, input bit wr, input logic [1:0] cap,
                         input logic [DW-1:0] dat);
    reqValid = 1; reqWrite = wr; reqLine = ln;
    tick();
    reqValid = 0;
    chkEq("R3", "acq aGrow", aGrow, wr ? 2'd0 : 2'd1);
    aReady = 1; tick(); aReady = 0;
    dValid = 1; dRelAck = 0; dCap = cap; dData = dat;
    tick(); dValid = 0;
    chkEq("R4", "eValid after grant", eValid, 1);
    eReady = 1; tick(); eReady = 0;
  endtask

  task automatic testReset();
    chkEq("R1", "aValid", aValid, 0);
    chkEq("R1", "cValid", cValid, 0);
    chkEq("R1", "eValid", eValid, 0);
    chkEq("R1", "rspValid", rspValid, 0);
    reqValid = 1; reqWrite = 0; reqLine = 2'd0;
    #1 chkEq("R1", "read of fresh line stalls", reqReady, 0);
    reqValid = 0; #1;
  endtask

  task automatic testReadMiss();
    reqValid = 1; reqWrite = 0; reqLine = 2'd1;
    #1 chkEq("R3", "read miss stalls", reqReady, 0);
    tick();
    chkEq("R3", "aValid", aValid, 1);
    chkEq("R3", "aLine", aLine, 1);
    chkEq("R3", "aGrow to-Branch", aGrow, 1);
    tick();
    chkEq("R10", "aValid held", aValid, 1);
    chkEq("R10", "aLine held", aLine, 1);
    aReady = 1; tick(); aReady = 0;
    chkEq("R3", "aValid dropped", aValid, 0);
    chkEq("R3", "still stalled", reqReady, 0);
    dValid = 1; dCap = 2'd1; dData = 32'h0000_00A1; dRelAck = 0;
    #1 chkEq("R4", "dReady", dReady, 1);
    tick(); dValid = 0;
    chkEq("R4", "eValid", eValid, 1);
    chkEq("R4", "eLine", eLine, 1);
    chkEq("R11", "no A/C while E", {30'd0, aValid, cValid}, 0);
    tick();
    chkEq("R10", "eValid held", eValid, 1);
    eReady = 1; tick(); eReady = 0;
    chkEq("R2", "read hit accepted", reqReady, 1);
    tick(); reqValid = 0;
    chkEq("R2", "rspValid", rspValid, 1);
    chkEq("R2", "rspData", rspData, 32'h0000_00A1);
    chkEq("R2", "no acquire on hit", aValid, 0);
  endtask

  task automatic testWriteUpgrade();
    reqValid = 1; reqWrite = 1; reqLine = 2'd1; reqData = 32'h1234_5678;
    #1 chkEq("R5", "write to Branch stalls", reqReady, 0);
    tick();
    chkEq("R3", "write aGrow to-Trunk", aGrow, 0);
    aReady = 1; tick(); aReady = 0;
    dValid = 1; dCap = 2'd0; dData = 32'h0000_00B2;
    tick(); dValid = 0;
    eReady = 1; tick(); eReady = 0;
    chkEq("R6", "write hit accepted", reqReady, 1);
    tick(); reqValid = 0;
    reqValid = 1; reqWrite = 0;
    tick(); reqValid = 0;
    chkEq("R6", "written data read back", rspData, 32'h1234_5678);
  endtask

  task automatic testProbeDirty();
    bValid = 1; bLine = 2'd1; bCap = 2'd1;
    #1 chkEq("R7", "bReady idle", bReady, 1);
    tick(); bValid = 0;
    chkEq("R7", "cValid", cValid, 1);
    chkEq("R7", "cReport to-Branch", cReport, 1);
    chkEq("R7", "cHasData dirty", cHasData, 1);
    chkEq("R7", "cData", cData, 32'h1234_5678);
    chkEq("R7", "cVoluntary", cVoluntary, 0);
    tick();
    chkEq("R10", "cValid held", cValid, 1);
    cReady = 1; tick(); cReady = 0;
    reqValid = 1; reqWrite = 1; reqLine = 2'd1;
    #1 chkEq("R5", "write after downgrade stalls", reqReady, 0);
    reqWrite = 0;
    #1 chkEq("R7", "read after downgrade hits", reqReady, 1);
    reqValid = 0;
    bValid = 1; bLine = 2'd1; bCap = 2'd1;
    tick(); bValid = 0;
    chkEq("R7", "clean Branch probe report", cReport, 1);
    chkEq("R7", "clean probe no data", cHasData, 0);
    cReady = 1; tick(); cReady = 0;
  endtask

  task automatic testProbeDuringAcquire();
    reqValid = 1; reqWrite = 1; reqLine = 2'd1; reqData = 32'hCAFE_0001;
    tick();
    aReady = 1; tick(); aReady = 0;
    bValid = 1; bLine = 2'd1; bCap = 2'd2;
    dValid = 1; dCap = 2'd0; dData = 32'h0000_00C3;
    #1 chkEq("R8", "grant held off by probe", dReady, 0);
    chkEq("R8", "probe taken", bReady, 1);
    tick(); bValid = 0;
    chkEq("R8", "probe answered first", cValid, 1);
    chkEq("R8", "report to-None", cReport, 2);
    chkEq("R8", "cLine", cLine, 1);
    chkEq("R8", "no ack yet", eValid, 0);
    cReady = 1; tick(); cReady = 0;
    chkEq("R8", "dReady after answer", dReady, 1);
    tick(); dValid = 0;
    chkEq("R8", "acquire completes", eValid, 1);
    eReady = 1; tick(); eReady = 0;
    chkEq("R8", "write proceeds", reqReady, 1);
    tick(); reqValid = 0;
  endtask

  task automatic testReleaseTrunk();
    relValid = 1; relLine = 2'd1;
    #1 chkEq("R9", "relReady", relReady, 1);
    tick(); relValid = 0;
    chkEq("R9", "cValid", cValid, 1);
    chkEq("R9", "cVoluntary", cVoluntary, 1);
    chkEq("R9", "cReport", cReport, 2);
    chkEq("R9", "cHasData", cHasData, 1);
    chkEq("R9", "cData", cData, 32'hCAFE_0001);
    cReady = 1; tick(); cReady = 0;
    chkEq("R9", "waiting for release ack", dReady, 1);
    dValid = 1; dRelAck = 1; tick(); dValid = 0; dRelAck = 0;
    reqValid = 1; reqWrite = 0; reqLine = 2'd1;
    #1 chkEq("R9", "released line invalid", reqReady, 0);
    reqValid = 0; #1;
  endtask

  task automatic testReleaseBranch();
    acquire(2'd3, 0, 2'd1, 32'h0000_0D44);
    relValid = 1; relLine = 2'd3;
    tick(); relValid = 0;
    chkEq("R9", "silent branch drop", cValid, 0);
    reqValid = 1; reqWrite = 0; reqLine = 2'd3;
    #1 chkEq("R9", "branch dropped", reqReady, 0);
    reqValid = 0; #1;
  endtask

  task automatic testProbeInvalid();
    bValid = 1; bLine = 2'd0; bCap = 2'd2;
    tick(); bValid = 0;
    chkEq("R7", "invalid probe report", cReport, 2);
    chkEq("R7", "invalid probe no data", cHasData, 0);
    cReady = 1; tick(); cReady = 0;
    acquire(2'd2, 1, 2'd0, 32'h0000_0E55);
    bValid = 1; bLine = 2'd2; bCap = 2'd0;
    tick(); bValid = 0;
    chkEq("R7", "keep probe report Trunk", cReport, 0);
    cReady = 1; tick(); cReady = 0;
    reqValid = 1; reqWrite = 1; reqLine = 2'd2;
    #1 chkEq("R7", "Trunk kept", reqReady, 1);
    reqValid = 0; #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    testReset();
    testReadMiss();
    testWriteUpgrade();
    testProbeDirty();
    testProbeDuringAcquire();
    testReleaseTrunk();
    testReleaseBranch();
    testProbeInvalid();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule